// File: doc/BRIEF.md
# Virtual Interrupt Residency Gate

This block sits after interrupt translation. It takes a virtual interrupt, named by a target virtual processor number (vPE) and a virtual interrupt number (vINT), and decides what happens to it. If the target vPE is the one now scheduled on the attached physical core and the interrupt is enabled, the block hands the interrupt straight to the virtual CPU interface. Otherwise it records the interrupt as pending in a per-vPE bit array, and it forwards the interrupt later.

A residency register holds a valid flag and the number of the scheduled vPE. A clear flag means no vPE is scheduled. An enable array holds one bit per vPE and interrupt. When software makes a vPE resident, every pending and enabled interrupt of that vPE is replayed to the CPU interface. The replay runs one interrupt per cycle, lowest vINT first. If an interrupt is enabled while it is pending for the resident vPE, it is replayed in the same way. The output uses a valid/ready handshake. The input is stalled while a replay is due or while the output is blocked.

Top module: `vint_residency_gate`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The residency flag is clear, no interrupt is pending and every enable bit is 0.
- R2: An accepted interrupt is forwarded in the next cycle when three things hold: the residency flag is set, `in_vpe` equals the resident vPE, and its enable bit is 1. Forwarding means `out_valid`=1 with `out_vpe`/`out_vint` equal to the input. The pending array is not changed.
- R3: An accepted interrupt whose vPE is not resident, or that arrives while the residency flag is clear, produces no output and sets its pending bit.
- R4: An accepted interrupt for the resident vPE whose enable bit is 0 produces no output and sets its pending bit. It is not forwarded while it stays disabled.
- R5: A residency write with the flag set makes the block replay that vPE's pending and enabled interrupts. The replay is in ascending vINT order, one per accepted output cycle, and each pending bit is cleared as its interrupt is forwarded. The first replayed interrupt appears two cycles after the write is sampled. A second residency write to the same vPE replays nothing.
- R6: If an interrupt is pending for the resident vPE and its enable bit is then written to 1, the interrupt is replayed as in R5.
- R7: `in_ready` is 0 whenever a pending and enabled interrupt of the resident vPE remains, and whenever `out_valid`=1 with `out_ready`=0.
- R8: While `out_valid`=1 and `out_ready`=0, the output holds `out_valid`, `out_vpe` and `out_vint` unchanged.
- R9: A residency write with the flag clear replays nothing. Enabling a pending interrupt while no vPE is resident forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_we | input | 1 | Write strobe for the residency register |
| res_valid_in | input | 1 | New residency flag (1 = a vPE is scheduled) |
| res_vpe_in | input | log2(NUM_VPE) | New resident vPE number |
| cfg_we | input | 1 | Write strobe for one enable bit |
| cfg_vpe | input | log2(NUM_VPE) | vPE of the enable bit |
| cfg_vint | input | log2(NUM_VINT) | vINT of the enable bit |
| cfg_en | input | 1 | New enable value |
| in_valid | input | 1 | Incoming virtual interrupt is valid |
| in_ready | output | 1 | Block can accept an incoming interrupt |
| in_vpe | input | log2(NUM_VPE) | Target vPE of the incoming interrupt |
| in_vint | input | log2(NUM_VINT) | Virtual interrupt number of the incoming interrupt |
| out_valid | output | 1 | Interrupt offered to the virtual CPU interface |
| out_ready | input | 1 | CPU interface takes the offered interrupt |
| out_vpe | output | log2(NUM_VPE) | vPE of the offered interrupt |
| out_vint | output | log2(NUM_VINT) | vINT of the offered interrupt |

## Verification
A direct hit is due one cycle after the accepting edge. The bench drives inputs on the falling edge, passes one rising edge, and reads the output on the next falling edge. A replay starts two cycles after the residency or enable write is sampled: one edge to update the register, one to load the output. After that the bench expects one interrupt per following edge, in ascending vINT order, and then `out_valid` low one edge after the last one. Pending state is not visible at the ports. Parked and cleared bits are therefore checked through the order and content of later replays, which the bench predicts from its own model of the enable and pending arrays.

// File: rtl/vint_residency_gate.sv
module vint_residency_gate #(
  parameter int NUM_VPE  = 4,
  parameter int NUM_VINT = 16,
  localparam int VW = (NUM_VPE  > 1) ? $clog2(NUM_VPE)  : 1,
  localparam int IW = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_we,
  input  logic          res_valid_in,
  input  logic [VW-1:0] res_vpe_in,
  input  logic          cfg_we,
  input  logic [VW-1:0] cfg_vpe,
  input  logic [IW-1:0] cfg_vint,
  input  logic          cfg_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_vpe,
  input  logic [IW-1:0] in_vint,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_vpe,
  output logic [IW-1:0] out_vint
);

  logic                res_valid;
  logic [VW-1:0]       res_vpe;
  logic [NUM_VINT-1:0] en_q   [NUM_VPE];
  logic [NUM_VINT-1:0] pend_q [NUM_VPE];

  logic [NUM_VINT-1:0] work;
  logic [IW-1:0]       pick;
  logic                has_work, out_free, accept, hit, drain_fire;

  assign work = res_valid ? (pend_q[res_vpe] & en_q[res_vpe]) : '0;
  assign has_work = |work;

  always_comb begin
    pick = '0;
    for (int i = NUM_VINT - 1; i >= 0; i--)
      if (work[i]) pick = IW'(i);
  end

  assign out_free   = !out_valid || out_ready;
  assign in_ready   = !has_work && out_free;
  assign accept     = in_valid && in_ready;
  assign hit        = accept && res_valid && (in_vpe == res_vpe) && en_q[in_vpe][in_vint];
  assign drain_fire = has_work && out_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_vpe   <= '0;
    end else if (res_we) begin
      res_valid <= res_valid_in;
      res_vpe   <= res_vpe_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VPE; v++) begin
        en_q[v]   <= '0;
        pend_q[v] <= '0;
      end
    end else begin
      if (cfg_we) en_q[cfg_vpe][cfg_vint] <= cfg_en;
      if (accept && !hit) pend_q[in_vpe][in_vint] <= 1'b1;
      if (drain_fire) pend_q[res_vpe][pick] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vpe   <= '0;
      out_vint  <= '0;
    end else if (out_free) begin
      out_valid <= hit || drain_fire;
      if (drain_fire) begin
        out_vpe  <= res_vpe;
        out_vint <= pick;
      end else if (hit) begin
        out_vpe  <= in_vpe;
        out_vint <= in_vint;
      end
    end
  end

endmodule

// File: rtl/vint_residency_gate_chk.sv
module vint_residency_gate_chk #(
  parameter int NUM_VPE  = 4,
  parameter int NUM_VINT = 16,
  localparam int VW = (NUM_VPE  > 1) ? $clog2(NUM_VPE)  : 1,
  localparam int IW = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [VW-1:0] in_vpe,
  input logic [IW-1:0] in_vint,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_vpe,
  input logic [IW-1:0] out_vint,
  input logic          res_valid,
  input logic [VW-1:0] res_vpe,
  input logic          has_work,
  input logic          hit
);

  // R2
  direct_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> out_valid && out_vint == $past(in_vint) && out_vpe == $past(in_vpe));

  // R3
  park_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !res_valid) |=> !out_valid);

  // R5
  replay_vpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (has_work && (!out_valid || out_ready)) |=> out_valid && out_vpe == $past(res_vpe));

  // R7
  in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (has_work || (out_valid && !out_ready)) |-> !in_ready);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_vint) && $stable(out_vpe));

endmodule

bind vint_residency_gate vint_residency_gate_chk #(.NUM_VPE(NUM_VPE), .NUM_VINT(NUM_VINT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_vpe(in_vpe), .in_vint(in_vint), .out_valid(out_valid), .out_ready(out_ready),
  .out_vpe(out_vpe), .out_vint(out_vint), .res_valid(res_valid), .res_vpe(res_vpe),
  .has_work(has_work), .hit(hit)
);

// File: tb/vint_residency_gate_tb.sv
module vint_residency_gate_tb;
  localparam int NV = 4;
  localparam int NI = 16;

  logic clk = 0, rst_n = 0;
  logic res_we = 0, res_valid_in = 0, cfg_we = 0, cfg_en = 0, in_valid = 0, out_ready = 1;
  logic [1:0] res_vpe_in = 0, cfg_vpe = 0, in_vpe = 0;
  logic [3:0] cfg_vint = 0, in_vint = 0;
  logic in_ready, out_valid;
  logic [1:0] out_vpe;
  logic [3:0] out_vint;

  int checks = 0, fails = 0;
  bit m_en [NV][NI];
  bit m_pend [NV][NI];
  bit m_rv = 0;
  int m_rvpe = 0;

  always #2 clk = ~clk;

  vint_residency_gate u_dut (.*);

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_drain(string req);
    check(in_ready == !(m_rv && has_model_work()), {req, " in_ready"}, in_ready, !(m_rv && has_model_work()));
    for (int i = 0; i < NI; i++) begin
      if (m_rv && m_pend[m_rvpe][i] && m_en[m_rvpe][i]) begin
        tick();
        check(out_valid && out_vint == i && out_vpe == m_rvpe, req, out_vint, i);
        m_pend[m_rvpe][i] = 0;
      end
    end
    tick();
    check(!out_valid && in_ready, {req, " idle after replay"}, out_valid, 0);
  endtask

  function automatic bit has_model_work();
    for (int i = 0; i < NI; i++)
      if (m_pend[m_rvpe][i] && m_en[m_rvpe][i]) return 1;
    return 0;
  endfunction

  task automatic set_res(bit v, int vpe, string req);
    res_we = 1; res_valid_in = v; res_vpe_in = 2'(vpe);
    tick();
    res_we = 0;
    m_rv = v; m_rvpe = vpe;
    expect_drain(req);
  endtask

  task automatic set_en(int vpe, int vint, bit e, string req);
    cfg_we = 1; cfg_vpe = 2'(vpe); cfg_vint = 4'(vint); cfg_en = e;
    tick();
    cfg_we = 0;
    m_en[vpe][vint] = e;
    expect_drain(req);
  endtask

  task automatic send(int vpe, int vint, string req);
    bit exp_hit;
    check(in_ready, {req, " in_ready before send"}, in_ready, 1);
    in_valid = 1; in_vpe = 2'(vpe); in_vint = 4'(vint);
    exp_hit = m_rv && vpe == m_rvpe && m_en[vpe][vint];
    tick();
    in_valid = 0;
    if (exp_hit) check(out_valid && out_vint == vint && out_vpe == vpe, req, out_vint, vint);
    else begin
      check(!out_valid, req, out_valid, 0);
      m_pend[vpe][vint] = 1;
    end
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) tick();
    rst_n = 1;
    tick();
    check(!out_valid, "R1 out_valid", out_valid, 0);
    check(in_ready, "R1 in_ready", in_ready, 1);

    set_en(2, 5, 1, "R9 enable while not resident");
    set_en(2, 9, 1, "R9 enable while not resident");
    send(2, 9, "R3 no resident vPE");
    send(2, 5, "R3 no resident vPE");
    send(2, 1, "R3 no resident vPE");
    set_res(1, 2, "R5 ascending replay");
    set_res(1, 2, "R5 bits cleared no second replay");
    send(2, 3, "R4 disabled parked");
    set_en(2, 3, 1, "R6 enabled while pending");
    set_en(2, 1, 1, "R6 enabled while pending");
    send(2, 5, "R2 direct delivery");
    send(0, 5, "R3 other vPE parked");
    set_res(0, 0, "R9 invalid residency");
    set_en(0, 5, 1, "R9 enable with no resident");
    set_res(1, 0, "R5 replay after becoming resident");

    out_ready = 0;
    in_valid = 1; in_vpe = 0; in_vint = 5;
    tick();
    in_valid = 0;
    for (int k = 0; k < 3; k++) begin
      check(out_valid && out_vint == 5, "R8 hold under backpressure", out_vint, 5);
      check(!in_ready, "R7 stall while output blocked", in_ready, 0);
      tick();
    end
    out_ready = 1;
    tick();
    check(!out_valid && in_ready, "R8 released", out_valid, 0);

    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      int v = $urandom_range(0, NV - 1);
      int i = $urandom_range(0, NI - 1);
      if (op < 6) send(v, i, "R2 R3 R4 random send");
      else if (op < 8) set_en(v, i, 1'($urandom_range(0, 1)), "R6 random enable");
      else set_res(1'($urandom_range(0, 3) != 0), v, "R5 random residency");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule